// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block copies a fixed-length run of 160 bytes out of a 256-byte page of the system address space into the sprite attribute table. The copy begins when software writes a page number. The engine then waits a fixed lead-in time. After that it moves one byte per slot at a steady pace. In each slot it issues a byte read on a memory-side port and a byte write into the sprite table. Page numbers in the top eighth of the address space are folded down, so the source always lies in ordinary memory. A fresh page write while a copy is running abandons that copy and starts over from byte zero with the new page.

While a copy is running, the engine also decodes each CPU access by its upper address byte and decides whether the access collides with the copy. The address space is grouped into 8 KB slices, and each slice belongs to one bus class. A CPU access is blocked when it lands on the same class as the copy source, unless that class is internal to the CPU. Any access to the sprite table page is also blocked. A blocked read returns all ones and a blocked write is not forwarded. A mode input selects whether the work RAM slices share the main bus or form a bus of their own. The memories themselves live outside this block.

Top module: `sprite_dma_top`

## Requirements
- R1: After reset `busy`, `oamWrEn` and `srcRdReq` are 0.
- R2: After `startWr` is sampled with page P, exactly 160 sprite-table writes occur. Write i puts byte i of source page P (source address P*256+i, read through `srcRdAddr` in the same cycle) at `oamWrAddr` = i, in ascending order.
- R3: A page value of 0xE0 or above is folded by clearing bit 5 (P AND 0xDF). For example, page 0xF1 reads from 0xD100 upward.
- R4: The first byte is written on the 8th rising edge after the edge that samples `startWr`. `oamWrEn` is high during the cycle that ends at that edge.
- R5: Each following byte is written exactly 4 rising edges after the previous one.
- R6: `busy` rises on the edge that samples `startWr` and falls on the edge that commits the 160th byte.
- R7: A `startWr` during a running copy restarts it: the timing of R4 and the address sequence of R2 start again from byte 0 with the new page, and no further bytes come from the old page.
- R8: While `busy` is high, a CPU access whose bus class equals the class of the copy source is blocked. A blocked read returns 0xFF on `cpuRdata`, and a blocked write leaves `memWe` at 0. Bus classes use the upper three address bits: 0x00-0x7F and 0xA0-0xBF in the upper byte are main, 0x80-0x9F is video, and 0xE0-0xFF is CPU-internal.
- R9: While `busy` is high, CPU-internal accesses (upper byte 0xE0-0xFD and 0xFF) are never blocked by class.
- R10: While `busy` is high, every CPU access with upper byte 0xFE is blocked.
- R11: Upper bytes 0xC0-0xDF belong to the main class when `colourMode` is 0 and to a separate RAM class when `colourMode` is 1.
- R12: While `busy` is low, no CPU access is blocked: `cpuRdata` equals `cpuRdataIn`, and `memWe` follows `cpuReq` AND `cpuWe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colourMode | input | 1 | 1 selects a separate work-RAM bus class |
| startWr | input | 1 | Page register write, starts or restarts a copy |
| startPage | input | 8 | Source page number written with `startWr` |
| srcRdReq | output | 1 | Source byte read strobe |
| srcRdAddr | output | 16 | Source byte address |
| srcRdData | input | 8 | Source byte, returned in the same cycle |
| oamWrEn | output | 1 | Sprite table write strobe |
| oamWrAddr | output | 8 | Sprite table byte offset |
| oamWrData | output | 8 | Sprite table write data |
| cpuReq | input | 1 | CPU access valid |
| cpuWe | input | 1 | CPU access is a write |
| cpuAddrHi | input | 8 | Upper byte of the CPU address |
| cpuRdataIn | input | 8 | Read data from the memory system |
| cpuRdata | output | 8 | Read data returned to the CPU |
| memWe | output | 1 | CPU write forwarded to the memory system |
| busy | output | 1 | Copy in progress |

## Verification
Copies are run from several pages: a main-bus page, a video page, a work-RAM page in each mode, and a page above 0xE0. Because every source byte is a function of its full address, a folding error or an index slip shows up as a data mismatch, not only as a wrong address. A copy is restarted a few slots in, which separates a true restart from a continuation or an ignored command. CPU probes cover each bus class under both mode settings, plus the sprite-table page and the CPU-internal area. This separates blocking by matching class from blocking of everything and from blocking of nothing, and the same probes are repeated while idle.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  localparam int XFER_LEN    = 160;
  localparam int FIRST_DELAY = 8;
  localparam int BYTE_GAP    = 4;
  localparam int PAGE_W      = 8;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 8;
  localparam int IDX_W       = $clog2(XFER_LEN);
  localparam int CNT_W       = $clog2(FIRST_DELAY) + 1;
  localparam logic [PAGE_W-1:0] FOLD_LIMIT = 8'hE0;
  localparam logic [PAGE_W-1:0] FOLD_MASK  = 8'hDF;
  localparam logic [PAGE_W-1:0] OAM_PAGE   = 8'hFE;

  typedef enum logic [1:0] {
    BUS_CPU,
    BUS_MAIN,
    BUS_VIDEO,
    BUS_WRAM
  } busClassT;

  typedef struct packed {
    logic load;
    logic step;
  } dmaStrobeT;

  function automatic busClassT classifySlice(input logic [2:0] slice, input logic colour);
    busClassT cls;
    case (slice)
      3'd4:    cls = BUS_VIDEO;
      3'd6:    cls = colour ? BUS_WRAM : BUS_MAIN;
      3'd7:    cls = BUS_CPU;
      default: cls = BUS_MAIN;
    endcase
    return cls;
  endfunction

endpackage

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl
  import sprite_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startWr,
  input  logic      lastByte,
  output dmaStrobeT strobe,
  output logic      active
);

  localparam logic [CNT_W-1:0] FIRST_LOAD = CNT_W'(FIRST_DELAY - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD   = CNT_W'(BYTE_GAP - 1);

  logic [CNT_W-1:0] waitCnt;
  logic             slotDue;

  assign slotDue      = active && (waitCnt == '0);
  assign strobe.load  = startWr;
  assign strobe.step  = slotDue && !startWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      waitCnt <= '0;
    end else if (startWr) begin
      active  <= 1'b1;
      waitCnt <= FIRST_LOAD;
    end else if (active) begin
      if (waitCnt == '0) begin
        if (lastByte) begin
          active <= 1'b0;
        end else begin
          waitCnt <= GAP_LOAD;
        end
      end else begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  a_r4_no_step_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.step);

  a_r5_step_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> !strobe.step);

  a_r6_end_on_step: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> $past(strobe.step));

endmodule

// File: rtl/sprite_dma_path.sv
module sprite_dma_path
  import sprite_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobeT         strobe,
  input  logic [PAGE_W-1:0] startPage,
  input  logic [DATA_W-1:0] srcRdData,
  output logic [PAGE_W-1:0] srcPage,
  output logic [ADDR_W-1:0] srcRdAddr,
  output logic              srcRdReq,
  output logic              oamWrEn,
  output logic [IDX_W-1:0]  oamWrAddr,
  output logic [DATA_W-1:0] oamWrData,
  output logic              lastByte
);

  logic [IDX_W-1:0]  idx;
  logic [PAGE_W-1:0] foldedPage;

  assign foldedPage = (startPage >= FOLD_LIMIT) ? (startPage & FOLD_MASK) : startPage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPage <= '0;
      idx     <= '0;
    end else if (strobe.load) begin
      srcPage <= foldedPage;
      idx     <= '0;
    end else if (strobe.step) begin
      idx <= idx + 1'b1;
    end
  end

  assign srcRdAddr = {srcPage, {(ADDR_W-PAGE_W){1'b0}}} | ADDR_W'(idx);
  assign srcRdReq  = strobe.step;
  assign oamWrEn   = strobe.step;
  assign oamWrAddr = idx;
  assign oamWrData = srcRdData;
  assign lastByte  = (idx == IDX_W'(XFER_LEN - 1));

  a_r2_index_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=> (idx == $past(idx) + 1'b1));

  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (idx == '0));

endmodule

// File: rtl/sprite_dma_arb.sv
module sprite_dma_arb
  import sprite_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              colourMode,
  input  logic [PAGE_W-1:0] srcPage,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [PAGE_W-1:0] cpuAddrHi,
  input  logic [DATA_W-1:0] cpuRdataIn,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memWe
);

  busClassT dmaClass;
  busClassT cpuClass;
  logic     sameBus;
  logic     inOam;
  logic     blocked;

  assign dmaClass = classifySlice(srcPage[PAGE_W-1 -: 3], colourMode);
  assign cpuClass = classifySlice(cpuAddrHi[PAGE_W-1 -: 3], colourMode);
  assign sameBus  = (dmaClass != BUS_CPU) && (cpuClass == dmaClass);
  assign inOam    = (cpuAddrHi == OAM_PAGE);
  assign blocked  = busy && cpuReq && (sameBus || inOam);
  assign cpuRdata = blocked ? {DATA_W{1'b1}} : cpuRdataIn;
  assign memWe    = cpuReq && cpuWe && !blocked;

  a_r10_oam_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cpuAddrHi == OAM_PAGE) |-> !memWe);

  a_r10_oam_read_ones: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cpuReq && cpuAddrHi == OAM_PAGE) |-> (cpuRdata == {DATA_W{1'b1}}));

  a_r12_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cpuReq && cpuWe) |-> memWe);

endmodule

// File: rtl/sprite_dma_top.sv
module sprite_dma_top
  import sprite_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              colourMode,
  input  logic              startWr,
  input  logic [PAGE_W-1:0] startPage,
  output logic              srcRdReq,
  output logic [ADDR_W-1:0] srcRdAddr,
  input  logic [DATA_W-1:0] srcRdData,
  output logic              oamWrEn,
  output logic [IDX_W-1:0]  oamWrAddr,
  output logic [DATA_W-1:0] oamWrData,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [PAGE_W-1:0] cpuAddrHi,
  input  logic [DATA_W-1:0] cpuRdataIn,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memWe,
  output logic              busy
);

  dmaStrobeT         strobe;
  logic              lastByte;
  logic [PAGE_W-1:0] srcPage;

  sprite_dma_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startWr  (startWr),
    .lastByte (lastByte),
    .strobe   (strobe),
    .active   (busy)
  );

  sprite_dma_path i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startPage (startPage),
    .srcRdData (srcRdData),
    .srcPage   (srcPage),
    .srcRdAddr (srcRdAddr),
    .srcRdReq  (srcRdReq),
    .oamWrEn   (oamWrEn),
    .oamWrAddr (oamWrAddr),
    .oamWrData (oamWrData),
    .lastByte  (lastByte)
  );

  sprite_dma_arb i_arb (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .colourMode (colourMode),
    .srcPage    (srcPage),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .cpuAddrHi  (cpuAddrHi),
    .cpuRdataIn (cpuRdataIn),
    .cpuRdata   (cpuRdata),
    .memWe      (memWe)
  );

  a_r6_writes_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    oamWrEn |-> busy);

  a_r3_source_not_high: assert property (@(posedge clk) disable iff (!rstN)
    srcRdReq |-> (srcRdAddr[ADDR_W-1 -: 3] != 3'b111));

endmodule

// File: tb/test_sprite_dma_top.sv
module test_sprite_dma_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        colourMode = 1'b0;
  logic        startWr = 1'b0;
  logic [7:0]  startPage = 8'h00;
  logic        srcRdReq;
  logic [15:0] srcRdAddr;
  logic [7:0]  srcRdData;
  logic        oamWrEn;
  logic [7:0]  oamWrAddr;
  logic [7:0]  oamWrData;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [7:0]  cpuAddrHi = 8'h00;
  logic [7:0]  cpuRdataIn = 8'h33;
  logic [7:0]  cpuRdata;
  logic        memWe;
  logic        busy;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] srcModel(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  assign srcRdData = srcModel(srcRdAddr);

  sprite_dma_top i_sprite_dma_top (
    .clk(clk), .rstN(rstN), .colourMode(colourMode), .startWr(startWr),
    .startPage(startPage), .srcRdReq(srcRdReq), .srcRdAddr(srcRdAddr),
    .srcRdData(srcRdData), .oamWrEn(oamWrEn), .oamWrAddr(oamWrAddr),
    .oamWrData(oamWrData), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddrHi(cpuAddrHi),
    .cpuRdataIn(cpuRdataIn), .cpuRdata(cpuRdata), .memWe(memWe), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("[TB] FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  // Pulse startWr around one rising edge; returns at the first falling edge after it.
  task automatic kick(input logic [7:0] page);
    startWr = 1'b1;
    startPage = page;
    @(negedge clk);
    startWr = 1'b0;
  endtask

  // Full copy check; called at a falling edge.
  task automatic xferCheck(input logic [7:0] page, input logic [7:0] expPage, input string tag);
    int n = 0;
    int firstK = -1;
    int gapErr = 0;
    int addrErr = 0;
    int dataErr = 0;
    int busyErr = 0;
    int lastK = 0;
    kick(page);
    for (int k = 0; k < 700; k++) begin
      if (k <= 643 && !busy) busyErr++;
      if (k >= 644 && busy) busyErr++;
      if (oamWrEn) begin
        if (n == 0) firstK = k;
        else if (k - lastK != 4) gapErr++;
        lastK = k;
        if (oamWrAddr != n[7:0]) addrErr++;
        if (srcRdAddr != {expPage, n[7:0]} || !srcRdReq) addrErr++;
        if (oamWrData != srcModel({expPage, n[7:0]})) dataErr++;
        n++;
      end
      @(negedge clk);
    end
    check(n == 160, {tag, " R2 byte count"}, n, 160);
    check(addrErr == 0, {tag, " R2 address order"}, addrErr, 0);
    check(dataErr == 0, {tag, " R2 data"}, dataErr, 0);
    check(firstK == 7, {tag, " R4 first byte delay"}, firstK, 7);
    check(gapErr == 0, {tag, " R5 byte spacing"}, gapErr, 0);
    check(busyErr == 0, {tag, " R6 busy window"}, busyErr, 0);
  endtask

  task automatic probe(input logic [7:0] hi, input logic we, input bit expBlock, input string tag);
    cpuReq = 1'b1;
    cpuWe = we;
    cpuAddrHi = hi;
    #1;
    if (we) check(memWe == !expBlock, tag, memWe, !expBlock);
    else    check(cpuRdata == (expBlock ? 8'hFF : 8'h33), tag, cpuRdata, expBlock ? 8'hFF : 8'h33);
    cpuReq = 1'b0;
    cpuWe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(!busy && !oamWrEn && !srcRdReq, "R1 reset outputs", {busy, oamWrEn, srcRdReq}, 0);
  endtask

  task automatic testMainPage();
    xferCheck(8'h40, 8'h40, "main");
  endtask

  task automatic testFold();
    xferCheck(8'hF1, 8'hD1, "R3 fold");
    xferCheck(8'h83, 8'h83, "video");
  endtask

  task automatic testRestart();
    int early = 0;
    kick(8'h12);
    for (int k = 0; k < 20; k++) begin
      if (oamWrEn) early++;
      @(negedge clk);
    end
    check(early == 4, "R7 bytes before restart", early, 4);
    xferCheck(8'h34, 8'h34, "R7 restart");
  endtask

  task automatic testCpuMono();
    colourMode = 1'b0;
    kick(8'h20);
    probe(8'h05, 1'b0, 1'b1, "R8 main read blocked");
    probe(8'hA3, 1'b1, 1'b1, "R8 ext write dropped");
    probe(8'h88, 1'b0, 1'b0, "R8 video read passes");
    probe(8'h90, 1'b1, 1'b0, "R8 video write passes");
    probe(8'hC4, 1'b0, 1'b1, "R11 mono wram blocked");
    probe(8'hFE, 1'b0, 1'b1, "R10 oam read blocked");
    probe(8'hFE, 1'b1, 1'b1, "R10 oam write dropped");
    probe(8'hFF, 1'b0, 1'b0, "R9 high page passes");
    probe(8'hE2, 1'b1, 1'b0, "R9 echo write passes");
    waitIdle();
  endtask

  task automatic testCpuColour();
    colourMode = 1'b1;
    kick(8'h10);
    probe(8'hC4, 1'b0, 1'b0, "R11 colour wram passes");
    probe(8'h30, 1'b0, 1'b1, "R8 colour main blocked");
    waitIdle();
    kick(8'hE5);
    probe(8'hD0, 1'b1, 1'b1, "R11 wram source blocks wram");
    probe(8'h20, 1'b0, 1'b0, "R11 wram source main passes");
    probe(8'hFD, 1'b0, 1'b0, "R9 internal passes");
    waitIdle();
    colourMode = 1'b0;
  endtask

  task automatic testIdle();
    probe(8'h05, 1'b0, 1'b0, "R12 idle main read");
    probe(8'hFE, 1'b1, 1'b0, "R12 idle oam write");
    probe(8'hFE, 1'b0, 1'b0, "R12 idle oam read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testMainPage();
    testFold();
    testRestart();
    testCpuMono();
    testCpuColour();
    testIdle();
    finishRun();
  end

endmodule